// File: doc/BRIEF.md
# Seven-Segment Decimal Display Decoder with Zero Blanking

This block turns a fixed-point decimal number, held as one BCD code per digit, into active-low seven-segment drive for every digit of a display. Zeros that carry no meaning are blanked. In the integer part, a zero is dark when it and every digit above it are zero. In the fraction part, a zero is dark when it and every digit below it are zero. A zero that sits between significant digits stays lit, and the units digit always shows, so a value of zero reads as "0".

Each digit stage has a ripple-blank input and a ripple-blank output, both active-low. A stage goes dark and pulls its ripple output low only when its ripple input is asserted and its own code is 0. For integer digits, the ripple passes from the most significant digit downward. For fractional digits, it passes from the least significant digit upward, toward the decimal point. Each digit also has a force-blank input that turns its segments off. The whole chain is combinational.

Top module: `seg7_blank_display`

## Requirements
- R1: A shown digit with code 0 to 9 drives the usual decimal glyph, active-low. Bits 7*i+0 to 7*i+6 of `seg_n` are segments a, b, c, d, e, f and g of digit i, and a lit segment is 0. Digit 6 includes segment a, and digit 9 includes segment d.
- R2: An integer digit other than the units digit is blanked when its code and all higher integer codes are 0.
- R3: The units digit (index FRAC_DIGITS) is never blanked by the ripple chain, so it shows 0 when its code is 0.
- R4: A fractional digit is blanked when its code and all lower fractional codes are 0.
- R5: A zero that has a nonzero digit on its significant side (above it in the integer part, below it in the fraction part) stays lit.
- R6: `rbo_n[i]` is 0 exactly when digit i is blanked by the ripple chain, and it is 1 otherwise.
- R7: When `blank_force[i]` is 1, all seven segments of digit i are off (1) whatever its code. `rbo_n` is not affected.
- R8: Codes 10 to 15 drive all segments off, and they count as nonzero for the chain: the ripple output of that digit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| digits_bcd | input | 4*(INT_DIGITS+FRAC_DIGITS) | BCD code per digit; digit 0 is the least significant fractional digit |
| blank_force | input | INT_DIGITS+FRAC_DIGITS | Per-digit forced blanking, active-high |
| seg_n | output | 7*(INT_DIGITS+FRAC_DIGITS) | Active-low segments a..g per digit |
| rbo_n | output | INT_DIGITS+FRAC_DIGITS | Per-digit ripple-blank output, active-low |

## Verification
A short table of hand-worked values separates the main situations: all zeros, zeros embedded between significant digits, one significant digit on only one side of the point, and a full 9999.99. A sweep over all 10,000 integer parts, each paired with a changing fraction, tells leading-zero blanking apart from blanking of embedded zeros. A sweep over all 100 fractions, with several integer parts, does the same for trailing zeros. Directed cases then place codes 10 to 15 in the top digit to show that these codes stop the chain, and apply forced blanking to show that the segments go dark while the ripple outputs stay as they were.

// File: rtl/seg7_blank_display.sv
module seg7_blank_display #(
  parameter int INT_DIGITS  = 4,
  parameter int FRAC_DIGITS = 2,
  localparam int NUM_DIGITS = INT_DIGITS + FRAC_DIGITS
) (
  input  logic [4*NUM_DIGITS-1:0] digits_bcd,
  input  logic [NUM_DIGITS-1:0]   blank_force,
  output logic [7*NUM_DIGITS-1:0] seg_n,
  output logic [NUM_DIGITS-1:0]   rbo_n
);

  logic [NUM_DIGITS-1:0] rbi_n;
  logic [NUM_DIGITS-1:0] zero_dark;

  function automatic logic [6:0] glyph(input logic [3:0] code);
    case (code)
      4'd0: glyph = 7'b0111111;
      4'd1: glyph = 7'b0000110;
      4'd2: glyph = 7'b1011011;
      4'd3: glyph = 7'b1001111;
      4'd4: glyph = 7'b1100110;
      4'd5: glyph = 7'b1101101;
      4'd6: glyph = 7'b1111101;
      4'd7: glyph = 7'b0000111;
      4'd8: glyph = 7'b1111111;
      4'd9: glyph = 7'b1101111;
      default: glyph = 7'b0000000;
    endcase
  endfunction

  always_comb begin
    logic rip;
    rbi_n = '1;
    zero_dark = '0;
    rip = 1'b0;
    for (int i = NUM_DIGITS - 1; i >= FRAC_DIGITS; i--) begin
      rbi_n[i] = (i == FRAC_DIGITS) ? 1'b1 : rip;
      zero_dark[i] = !rbi_n[i] && (digits_bcd[4*i +: 4] == 4'd0);
      rip = !zero_dark[i];
    end
    rip = 1'b0;
    for (int j = 0; j < FRAC_DIGITS; j++) begin
      rbi_n[j] = rip;
      zero_dark[j] = !rbi_n[j] && (digits_bcd[4*j +: 4] == 4'd0);
      rip = !zero_dark[j];
    end
  end

  assign rbo_n = ~zero_dark;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    assign seg_n[7*g +: 7] = (blank_force[g] || zero_dark[g]) ? 7'h7F
                                                              : ~glyph(digits_bcd[4*g +: 4]);
  end

endmodule

// File: rtl/seg7_blank_display_chk.sv
module seg7_blank_display_chk #(
  parameter int INT_DIGITS  = 4,
  parameter int FRAC_DIGITS = 2,
  localparam int NUM_DIGITS = INT_DIGITS + FRAC_DIGITS
) (
  input logic [4*NUM_DIGITS-1:0] digits_bcd,
  input logic [NUM_DIGITS-1:0]   blank_force,
  input logic [7*NUM_DIGITS-1:0] seg_n,
  input logic [NUM_DIGITS-1:0]   rbo_n
);

  always_comb begin
    assert_units_shown_R3: assert (rbo_n[FRAC_DIGITS] == 1'b1);
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (blank_force[i])
        assert_force_dark_R7: assert (seg_n[7*i +: 7] == 7'h7F);
      if (!rbo_n[i])
        assert_ripple_dark_R6: assert (seg_n[7*i +: 7] == 7'h7F && digits_bcd[4*i +: 4] == 4'd0);
      if (digits_bcd[4*i +: 4] > 4'd9)
        assert_bad_code_R8: assert (rbo_n[i] && seg_n[7*i +: 7] == 7'h7F);
      if (rbo_n[i] && !blank_force[i] && digits_bcd[4*i +: 4] <= 4'd9)
        assert_glyph_lit_R1: assert (seg_n[7*i +: 7] != 7'h7F);
      if (i > FRAC_DIGITS && i < NUM_DIGITS - 1 && !rbo_n[i])
        assert_lead_chain_R2: assert (!rbo_n[i+1]);
      if (i > 0 && i < FRAC_DIGITS && !rbo_n[i])
        assert_trail_chain_R4: assert (!rbo_n[i-1]);
    end
  end

endmodule

bind seg7_blank_display seg7_blank_display_chk #(
  .INT_DIGITS(INT_DIGITS),
  .FRAC_DIGITS(FRAC_DIGITS)
) u_chk (
  .digits_bcd(digits_bcd),
  .blank_force(blank_force),
  .seg_n(seg_n),
  .rbo_n(rbo_n)
);

// File: tb/seg7_blank_display_bench.sv
module seg7_blank_display_bench;
  localparam int ND = 6;
  localparam int NF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4*ND-1:0] digits_bcd = '0;
  logic [ND-1:0]   blank_force = '0;
  logic [7*ND-1:0] seg_n;
  logic [ND-1:0]   rbo_n;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seg7_blank_display #(.INT_DIGITS(ND-NF), .FRAC_DIGITS(NF)) u_seg7_blank_display (
    .digits_bcd(digits_bcd), .blank_force(blank_force), .seg_n(seg_n), .rbo_n(rbo_n));

  localparam logic [6:0] LIT [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                                      7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};

  // {digits d5..d0, expected shown mask}
  localparam logic [29:0] VEC [8] = '{
    {24'h000000, 6'b000100},
    {24'h102030, 6'b111110},
    {24'h004507, 6'b001111},
    {24'h010000, 6'b011100},
    {24'h999999, 6'b111111},
    {24'h000050, 6'b000110},
    {24'h000700, 6'b000100},
    {24'h0A0000, 6'b011100}
  };

  function automatic logic [ND-1:0] shown_mask(input logic [4*ND-1:0] d);
    logic [ND-1:0] m = '0;
    bit seen = 0;
    for (int i = ND - 1; i >= NF; i--) begin
      if (d[4*i +: 4] != 0) seen = 1;
      m[i] = seen || (i == NF);
    end
    seen = 0;
    for (int j = 0; j < NF; j++) begin
      if (d[4*j +: 4] != 0) seen = 1;
      m[j] = seen;
    end
    return m;
  endfunction

  task automatic apply(input logic [4*ND-1:0] d, input logic [ND-1:0] f,
                       input logic [ND-1:0] mask, input string tag);
    logic [7*ND-1:0] exp_seg;
    @(posedge clk);
    digits_bcd = d;
    blank_force = f;
    for (int i = 0; i < ND; i++) begin
      if (f[i] || !mask[i] || d[4*i +: 4] > 9) exp_seg[7*i +: 7] = 7'h7F;
      else exp_seg[7*i +: 7] = ~LIT[d[4*i +: 4]];
    end
    @(negedge clk);
    n_checks++;
    if (seg_n !== exp_seg || rbo_n !== mask) begin
      n_fail++;
      $display("FAIL %s digits=%h seg_n=%h rbo_n=%b expected seg_n=%h rbo_n=%b",
               tag, d, seg_n, rbo_n, exp_seg, mask);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (seg_n !== {{3{7'h7F}}, ~LIT[0], {2{7'h7F}}} || rbo_n !== 6'b000100) begin
      n_fail++;
      $display("FAIL R3 reset state seg_n=%h rbo_n=%b expected units 0 only", seg_n, rbo_n);
    end
    rst_n = 1'b1;

    for (int k = 0; k < 8; k++)
      apply(VEC[k][29:6], '0, VEC[k][5:0], "R1/R2/R4/R5/R6 table");

    for (int v = 0; v < 10000; v++) begin
      logic [4*ND-1:0] d;
      d = {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10),
           4'((v / 7) % 10), 4'((v / 3) % 10)};
      apply(d, '0, shown_mask(d), "R2/R3/R5 integer sweep");
    end

    for (int base = 0; base < 3; base++)
      for (int fr = 0; fr < 100; fr++) begin
        logic [4*ND-1:0] d;
        d = {(base == 0) ? 16'h0000 : (base == 1) ? 16'h0005 : 16'h0100,
             4'(fr / 10), 4'(fr % 10)};
        apply(d, '0, shown_mask(d), "R4/R5 fraction sweep");
      end

    for (int c = 10; c < 16; c++) begin
      logic [4*ND-1:0] d;
      d = {4'(c), 20'h00000};
      apply(d, '0, 6'b111100, "R8 invalid code top digit");
      d = {16'h0000, 4'd0, 4'(c)};
      apply(d, '0, 6'b000111, "R8 invalid code low fraction");
    end

    apply(24'h102030, 6'b100100, 6'b111110, "R7 forced blank");
    apply(24'h000000, 6'b111111, 6'b000100, "R7 forced blank all");
    apply(24'h888888, 6'b010001, 6'b111111, "R7 forced blank eights");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule